// File: doc/BRIEF.md
# Output Emergency Shutdown Controller

This block decides when a motor-drive timer must lose control of its pins. It watches four active-low fault inputs and the present levels of six high-current drive outputs. It then issues per-pin high-impedance enables for two groups of outputs: the six high-current outputs and four general timer outputs. A pad ring or a timer output stage uses these enables to float the pins.

Each fault input first passes through a two-flop synchronizer. Software then selects, once after reset, how the input is qualified. The choices are a single falling edge, or a low level seen on 16 consecutive samples taken at the clock divided by 8, 16 or 128. The block also compares the three complementary driver pairs. If both members of a pair show their active level on a clock edge, the high-current group is floated. Software can float either group directly through control bits.

Every detection latches a sticky flag, and each flag can raise the shared interrupt when its enable bit is set. A flag holds the outputs floated until software reads it as 1 and then writes 0 to it. That clear does not take effect while the cause is still present.

Top module: `fault_hiz_ctrl`

## Requirements
- R1: After reset, `hc_hiz`, `gt_hiz` and `irq` are 0, and the registers at addresses 0, 1 and 2 read 0.
- R2: A fault input in detection mode 0 sets its flag on a falling edge, after a two-flop synchronizer. An input that stays low after its flag has been cleared does not set the flag again.
- R3: Mode 1, 2 and 3 sample the input every 8, 16 and 128 clocks. The flag is set only after 16 consecutive low samples.
- R4: In the sampled modes, a high sample restarts the count of low samples from zero.
- R5: Any set input flag (flag register bits 3:0, one per fault input) drives all six `hc_hiz` and all four `gt_hiz` bits to 1.
- R6: The compared pairs are `hc_lvl` indices (0,1), (2,4) and (3,5), with polarity bits CTRL[5], CTRL[6] and CTRL[7] (0 = active high, 1 = active low). When both members of a pair are active on a clock edge, the overlap flag (flag bit 4) is set from the next cycle. This floats all six `hc_hiz` bits but not `gt_hiz`. Other bit combinations have no effect.
- R7: CTRL[8] = 1 forces all `hc_hiz` bits to 1, and CTRL[9] = 1 forces all `gt_hiz` bits to 1, with no flag involved.
- R8: A flag clears only when 0 is written to its bit at address 1 after a read of address 1 returned that bit as 1. Writing 0 without that read, or writing 1, leaves it set.
- R9: While its cause persists, a flag cannot be cleared. The causes are a level still qualified low, or a pair still overlapping.
- R10: `irq` is the OR of the flags whose enable bit is set, with enables at CTRL[4:0] matching flag bits 4:0.
- R11: The mode register (address 0, two bits per input, input k at bits 2k+1:2k) accepts only its first write after reset. Later writes are ignored.
- R12: Register addresses are 0 (mode), 1 (flags) and 2 (CTRL). While `rd_en` is high, `rdata` shows the addressed register, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_n | input | 4 | Active-low fault inputs, asynchronous |
| hc_lvl | input | 6 | Present levels of the high-current drive outputs |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data |
| hc_hiz | output | 6 | High-impedance enables, high-current outputs |
| gt_hiz | output | 4 | High-impedance enables, general timer outputs |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets three classes of fault:

- **Sample counting.** An input released just before its 16th low sample must not trip. A design that keeps counting across a high sample would float the outputs on a glitch train. A divider wired to the wrong mode would trip too early or too late against the bench's windows.
- **Flag-clear protocol.** A clear written without a prior read must not take effect. A clear attempted while the cause is still present must fail. A design that gets either wrong releases the pins during an ongoing fault.
- **Comparator and mode register.** Near-miss level combinations must not trip the comparator, and a polarity flip must trip it at once. A second write to the mode register must not stick; a design that accepted it could silently switch a fault input to a slower detection mode.

// File: rtl/fault_hiz_pkg.sv
package fault_hiz_pkg;

   typedef enum logic [1:0] {
      DET_EDGE  = 2'd0,
      DET_DIV_A = 2'd1,
      DET_DIV_B = 2'd2,
      DET_DIV_C = 2'd3
   } det_mode_e;

   localparam int HC_W    = 6;
   localparam int N_PAIR  = 3;

   localparam logic [1:0] A_MODE = 2'd0;
   localparam logic [1:0] A_FLAG = 2'd1;
   localparam logic [1:0] A_CTRL = 2'd2;

   function automatic int pair_lo(input int p);
      case (p)
         0:       return 0;
         1:       return 2;
         default: return 3;
      endcase
   endfunction

   function automatic int pair_hi(input int p);
      case (p)
         0:       return 1;
         1:       return 4;
         default: return 5;
      endcase
   endfunction

endpackage

// File: rtl/fhz_strobe_gen.sv
module fhz_strobe_gen #(
   parameter int LOG_A = 3,
   parameter int LOG_B = 4,
   parameter int LOG_C = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic [2:0] stb
);
   localparam int CNT_W = LOG_C;
   localparam int LOGS [3] = '{LOG_A, LOG_B, LOG_C};

   if (LOG_A < 1 || LOG_B <= LOG_A || LOG_C <= LOG_B) begin : g_bad_div
      $error("fhz_strobe_gen: divider exponents must be strictly increasing and >= 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   for (genvar i = 0; i < 3; i++) begin : g_stb
      assign stb[i] = &cnt[LOGS[i]-1:0];
   end
endmodule

// File: rtl/fhz_fault_det.sv
module fhz_fault_det
   import fault_hiz_pkg::*;
#(
   parameter int SAMPLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flt_n,
   input  det_mode_e  mode,
   input  logic [2:0] stb,
   output logic       det
);
   localparam int CW = $clog2(SAMPLES + 1);
   localparam logic [CW-1:0] FULL = CW'(SAMPLES);

   if (SAMPLES < 2) begin : g_bad_samples
      $error("fhz_fault_det: SAMPLES must be at least 2");
   end

   logic [1:0]    sync_q;
   logic          prev_q;
   logic [CW-1:0] low_cnt;
   logic          lvl;
   logic          tick;

   assign lvl = sync_q[1];

   always_comb begin
      case (mode)
         DET_DIV_A: tick = stb[0];
         DET_DIV_B: tick = stb[1];
         DET_DIV_C: tick = stb[2];
         default:   tick = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 2'b11;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[0], flt_n};
         prev_q <= lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
      end else if (mode == DET_EDGE) begin
         low_cnt <= '0;
      end else if (tick) begin
         if (lvl)                  low_cnt <= '0;
         else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
      end
   end

   assign det = (mode == DET_EDGE) ? (prev_q & ~lvl)
                                   : ((low_cnt == FULL) & ~lvl);
endmodule

// File: rtl/fhz_overlap.sv
module fhz_overlap
   import fault_hiz_pkg::*;
(
   input  logic [HC_W-1:0]   lvl,
   input  logic [N_PAIR-1:0] act_low,
   output logic              ovl
);
   logic [N_PAIR-1:0] hit;

   for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
      localparam int LO = pair_lo(p);
      localparam int HI = pair_hi(p);
      assign hit[p] = (lvl[LO] ^ act_low[p]) & (lvl[HI] ^ act_low[p]);
   end

   assign ovl = |hit;
endmodule

// File: rtl/fhz_regs.sv
module fhz_regs
   import fault_hiz_pkg::*;
#(
   parameter int N_FLT  = 4,
   parameter int DATA_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  logic                wr_en,
   input  logic [1:0]          addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [N_FLT:0]      set_in,
   output logic [DATA_W-1:0]   rdata,
   output logic [2*N_FLT-1:0]  mode_q,
   output logic                mode_locked,
   output logic [N_FLT:0]      flags,
   output logic [N_FLT:0]      irq_en,
   output logic [N_PAIR-1:0]   act_low,
   output logic                sw_hc,
   output logic                sw_gt
);
   localparam int FLAG_W = N_FLT + 1;
   localparam int MODE_W = 2 * N_FLT;
   localparam int CTRL_W = FLAG_W + N_PAIR + 2;

   if (CTRL_W > DATA_W || MODE_W > DATA_W) begin : g_bad_width
      $error("fhz_regs: DATA_W too narrow for the register layout");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [FLAG_W-1:0] armed;
   logic [FLAG_W-1:0] clr;
   logic              unused_wdata;

   assign unused_wdata = ^wdata;

   assign clr = (wr_en && addr == A_FLAG) ? (armed & ~wdata[FLAG_W-1:0]) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= '0;
         mode_locked <= 1'b0;
      end else if (wr_en && addr == A_MODE && !mode_locked) begin
         mode_q      <= wdata[MODE_W-1:0];
         mode_locked <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ctrl_q <= '0;
      else if (wr_en && addr == A_CTRL) ctrl_q <= wdata[CTRL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         armed <= '0;
      end else begin
         flags <= set_in | (flags & ~clr);
         if (rd_en && addr == A_FLAG) armed <= flags;
         else                         armed <= armed & ~clr;
      end
   end

   assign irq_en  = ctrl_q[FLAG_W-1:0];
   assign act_low = ctrl_q[FLAG_W +: N_PAIR];
   assign sw_hc   = ctrl_q[FLAG_W + N_PAIR];
   assign sw_gt   = ctrl_q[FLAG_W + N_PAIR + 1];

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            A_MODE:  rdata[MODE_W-1:0] = mode_q;
            A_FLAG:  rdata[FLAG_W-1:0] = flags;
            A_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
            default: rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/fault_hiz_ctrl.sv
module fault_hiz_ctrl
   import fault_hiz_pkg::*;
#(
   parameter int N_FLT   = 4,
   parameter int GT_W    = 4,
   parameter int DATA_W  = 16,
   parameter int SAMPLES = 16,
   parameter int LOG_A   = 3,
   parameter int LOG_B   = 4,
   parameter int LOG_C   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_FLT-1:0]  flt_n,
   input  logic [HC_W-1:0]   hc_lvl,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [HC_W-1:0]   hc_hiz,
   output logic [GT_W-1:0]   gt_hiz,
   output logic              irq
);
   if (N_FLT < 1 || GT_W < 1) begin : g_bad_cfg
      $error("fault_hiz_ctrl: N_FLT and GT_W must be positive");
   end

   logic [2:0]          stb;
   logic [N_FLT-1:0]    det;
   logic                ovl;
   logic [2*N_FLT-1:0]  mode_q;
   logic                mode_locked;
   logic [N_FLT:0]      flags;
   logic [N_FLT:0]      irq_en;
   logic [N_PAIR-1:0]   act_low;
   logic                sw_hc;
   logic                sw_gt;
   logic                any_in;

   fhz_strobe_gen #(.LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C)) u_stb (
      .clk(clk), .rst_n(rst_n), .stb(stb)
   );

   for (genvar k = 0; k < N_FLT; k++) begin : g_in
      fhz_fault_det #(.SAMPLES(SAMPLES)) u_det (
         .clk(clk), .rst_n(rst_n), .flt_n(flt_n[k]),
         .mode(det_mode_e'(mode_q[2*k +: 2])), .stb(stb), .det(det[k])
      );
   end

   fhz_overlap u_ovl (.lvl(hc_lvl), .act_low(act_low), .ovl(ovl));

   fhz_regs #(.N_FLT(N_FLT), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .set_in({ovl, det}), .rdata(rdata), .mode_q(mode_q),
      .mode_locked(mode_locked), .flags(flags), .irq_en(irq_en),
      .act_low(act_low), .sw_hc(sw_hc), .sw_gt(sw_gt)
   );

   assign any_in = |flags[N_FLT-1:0];
   assign hc_hiz = {HC_W{any_in | flags[N_FLT] | sw_hc}};
   assign gt_hiz = {GT_W{any_in | sw_gt}};
   assign irq    = |(flags & irq_en);
endmodule

// File: rtl/fault_hiz_chk.sv
module fault_hiz_chk
   import fault_hiz_pkg::*;
#(
   parameter int N_FLT = 4,
   parameter int GT_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [1:0]         addr,
   input logic [HC_W-1:0]    hc_lvl,
   input logic [HC_W-1:0]    hc_hiz,
   input logic [GT_W-1:0]    gt_hiz,
   input logic               irq,
   input logic [2*N_FLT-1:0] mode_q,
   input logic               mode_locked,
   input logic [N_FLT:0]     flags,
   input logic [N_FLT:0]     irq_en,
   input logic [N_PAIR-1:0]  act_low,
   input logic               sw_hc,
   input logic               sw_gt
);
   logic [N_PAIR-1:0] pair_on;

   for (genvar p = 0; p < N_PAIR; p++) begin : g_p
      assign pair_on[p] = (hc_lvl[pair_lo(p)] == !act_low[p]) &&
                          (hc_lvl[pair_hi(p)] == !act_low[p]);
   end

   // R11
   mode_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_locked && wr_en && addr == A_MODE) |=> $stable(mode_q));

   // R8
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(flags) & ~flags)) |-> $past(wr_en && addr == A_FLAG));

   // R6
   pair_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|pair_on) |=> (flags[N_FLT] && (&hc_hiz)));

   // R6
   ovl_no_gt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|flags[N_FLT-1:0]) && !sw_gt) |-> (gt_hiz == '0));

   // R5
   in_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gt_hiz[0] && !sw_gt) |-> (&hc_hiz));

   // R7
   sw_hc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_hc |-> (&hc_hiz));

   // R7
   sw_gt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_gt |-> (&gt_hiz));

   // R10
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0) |-> !irq);
endmodule

bind fault_hiz_ctrl fault_hiz_chk #(.N_FLT(N_FLT), .GT_W(GT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .hc_lvl(hc_lvl),
   .hc_hiz(hc_hiz), .gt_hiz(gt_hiz), .irq(irq), .mode_q(mode_q),
   .mode_locked(mode_locked), .flags(flags), .irq_en(irq_en),
   .act_low(act_low), .sw_hc(sw_hc), .sw_gt(sw_gt)
);

// File: tb/fault_hiz_ctrl_test.sv
module fault_hiz_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  flt_n = 4'hF;
   logic [5:0]  hc_lvl = 6'h00;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = 16'h0;
   logic [15:0] rdata;
   logic [5:0]  hc_hiz;
   logic [3:0]  gt_hiz;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fault_hiz_ctrl uut (
      .clk(clk), .rst_n(rst_n), .flt_n(flt_n), .hc_lvl(hc_lvl),
      .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .hc_hiz(hc_hiz), .gt_hiz(gt_hiz), .irq(irq)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic read_clear(input logic [15:0] mask);
      logic [15:0] v;
      reg_rd(2'd1, v);
      reg_wr(2'd1, ~mask);
      idle(2);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      check("R1 hc_hiz", {10'd0, hc_hiz}, 16'h0);
      check("R1 gt_hiz", {12'd0, gt_hiz}, 16'h0);
      check("R1 irq", {15'd0, irq}, 16'h0);
      reg_rd(2'd0, v); check("R1 mode reg", v, 16'h0);
      reg_rd(2'd1, v); check("R1 flag reg", v, 16'h0);
      reg_rd(2'd2, v); check("R1 ctrl reg", v, 16'h0);
   endtask

   task automatic t_mode_once;
      logic [15:0] v;
      reg_wr(2'd0, 16'h00B4);
      reg_rd(2'd0, v); check("R11 first write", v, 16'h00B4);
      reg_wr(2'd0, 16'h0000);
      reg_rd(2'd0, v); check("R11 second write ignored", v, 16'h00B4);
      reg_rd(2'd3, v); check("R12 unused address", v, 16'h0);
   endtask

   task automatic t_edge;
      logic [15:0] v;
      @(negedge clk); flt_n[0] = 1'b0;
      idle(2);
      check("R2 not before sync", {10'd0, hc_hiz}, 16'h0);
      idle(3);
      check("R5 hc floated", {10'd0, hc_hiz}, 16'h003F);
      check("R5 gt floated", {12'd0, gt_hiz}, 16'h000F);
      check("R10 irq masked", {15'd0, irq}, 16'h0);
      reg_wr(2'd2, 16'h0001); idle(1);
      check("R10 irq enabled", {15'd0, irq}, 16'h1);
      reg_wr(2'd2, 16'h0000);
      reg_wr(2'd1, 16'h0000); idle(2);
      check("R8 clear without read", {12'd0, gt_hiz}, 16'h000F);
      reg_rd(2'd1, v); check("R12 flag bit0", v, 16'h0001);
      reg_wr(2'd1, 16'h0001); idle(2);
      check("R8 write one keeps", {12'd0, gt_hiz}, 16'h000F);
      reg_wr(2'd1, 16'hFFFE); idle(2);
      check("R2 held low clears", {12'd0, gt_hiz}, 16'h0);
      idle(10);
      check("R2 no retrigger while low", {10'd0, hc_hiz}, 16'h0);
      @(negedge clk); flt_n[0] = 1'b1;
      idle(5);
   endtask

   task automatic t_level(input int pin, input int div, input string tag);
      logic [15:0] v;
      @(negedge clk); flt_n[pin] = 1'b0;
      idle(div * 13);
      check({tag, " R3 early"}, {12'd0, gt_hiz}, 16'h0);
      idle(div * 5 + 10);
      check({tag, " R3 tripped"}, {12'd0, gt_hiz}, 16'h000F);
      reg_rd(2'd1, v); check({tag, " R3 flag"}, v, 16'h1 << pin);
      reg_wr(2'd1, ~(16'h1 << pin)); idle(2);
      check({tag, " R9 still low"}, {12'd0, gt_hiz}, 16'h000F);
      @(negedge clk); flt_n[pin] = 1'b1;
      idle(div + 5);
      read_clear(16'h1 << pin);
      check({tag, " R9 released"}, {12'd0, gt_hiz}, 16'h0);
   endtask

   task automatic t_glitch;
      @(negedge clk); flt_n[1] = 1'b0;
      idle(80);
      @(negedge clk); flt_n[1] = 1'b1;
      idle(20);
      @(negedge clk); flt_n[1] = 1'b0;
      idle(100);
      check("R4 count restarted", {12'd0, gt_hiz}, 16'h0);
      idle(50);
      check("R4 trips after full run", {12'd0, gt_hiz}, 16'h000F);
      @(negedge clk); flt_n[1] = 1'b1;
      idle(20);
      read_clear(16'h0002);
      check("R4 cleared", {12'd0, gt_hiz}, 16'h0);
   endtask

   task automatic t_overlap;
      logic [15:0] v;
      @(negedge clk); hc_lvl = 6'b000101;
      idle(3);
      check("R6 non-pair ignored", {10'd0, hc_hiz}, 16'h0);
      @(negedge clk); hc_lvl = 6'b010100;
      @(negedge clk); hc_lvl = 6'b000000;
      idle(1);
      check("R6 pair trip hc", {10'd0, hc_hiz}, 16'h003F);
      check("R6 pair no gt", {12'd0, gt_hiz}, 16'h0);
      reg_rd(2'd1, v); check("R6 overlap flag", v, 16'h0010);
      reg_wr(2'd2, 16'h0010); idle(1);
      check("R10 overlap irq", {15'd0, irq}, 16'h1);
      reg_wr(2'd2, 16'h0000);
      reg_wr(2'd1, 16'h000F); idle(2);
      check("R8 overlap cleared", {10'd0, hc_hiz}, 16'h0);
      @(negedge clk); hc_lvl = 6'b101000;
      idle(2);
      read_clear(16'h0010);
      check("R9 overlap persists", {10'd0, hc_hiz}, 16'h003F);
      @(negedge clk); hc_lvl = 6'b000000;
      read_clear(16'h0010);
      check("R9 overlap released", {10'd0, hc_hiz}, 16'h0);
      reg_wr(2'd2, 16'h0020); idle(1);
      check("R6 active-low pair", {10'd0, hc_hiz}, 16'h003F);
      reg_wr(2'd2, 16'h0000);
      read_clear(16'h0010);
      check("R6 polarity restored", {10'd0, hc_hiz}, 16'h0);
   endtask

   task automatic t_force;
      reg_wr(2'd2, 16'h0100); idle(1);
      check("R7 sw hc", {10'd0, hc_hiz}, 16'h003F);
      check("R7 sw hc gt idle", {12'd0, gt_hiz}, 16'h0);
      reg_wr(2'd2, 16'h0200); idle(1);
      check("R7 sw gt", {12'd0, gt_hiz}, 16'h000F);
      check("R7 sw gt hc idle", {10'd0, hc_hiz}, 16'h0);
      reg_wr(2'd2, 16'h0000); idle(1);
      check("R7 release", {12'd0, gt_hiz}, 16'h0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset;
      t_mode_once;
      t_edge;
      t_glitch;
      t_level(1, 8, "div8");
      t_level(3, 16, "div16");
      t_level(2, 128, "div128");
      t_overlap;
      t_force;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule